// File: doc/BRIEF.md
# Refresh-Snooping Character Row Fetcher

This block feeds a character-mode display without ever taking the CPU bus. The CPU already runs a DRAM refresh cycle after each instruction fetch. During that cycle the upper address byte comes from the CPU's interrupt-vector register, and the low seven bits come from its refresh counter. Software points the vector register at a screen row, starts capture, and runs code. Each refresh cycle then presents one screen byte on the data bus, and this block latches it.

The captured bytes go into the fill half of a two-bank row store that holds 80 characters per bank. The other bank is the display half. It is read once per scanline at the column the video timing asks for. The same bytes are therefore reused for every scanline of an 8-line character cell. At the end of the last scanline of a cell row the banks trade places, and the new fill side starts out empty. A status output reports whether the row that was just promoted to display was only partly captured.

The block presents the character code and the scanline-within-cell as the address for a glyph ROM. That ROM and the pixel shifter sit outside this block.

Top module: `refresh_row_fetcher`

## Requirements
- R1: After reset, `glyph_code`, `glyph_row` and `underrun` are all zero, and both banks read as zero.
- R2: A byte is captured once per refresh cycle, on the first clock where `refresh` and `mem_req` are both high after they were not. The byte is written into the fill bank at index `ref_addr` (seven bits, value 0..127). Captured bytes become visible on `glyph_code` only after the next bank swap.
- R3: A capture whose index is 80 or more is discarded and changes no slot of either bank.
- R4: While `fill_en` is low, refresh cycles capture nothing.
- R5: A memory request without `refresh`, or `refresh` without `mem_req`, captures nothing.
- R6: Each `line_end` pulse advances the scanline count. `glyph_row` shows this count, 0..7. The banks swap on the `line_end` pulse that ends scanline 7, and the scanline count then returns to 0.
- R7: The display bank is unaffected by captures. Every scanline of a cell row shows the same 80 bytes.
- R8: At each swap, `underrun` is set to 1 if fewer than 80 distinct slots were captured since the previous swap, and to 0 otherwise. It holds that value until the next swap.
- R9: `glyph_code` is the display-bank byte at `disp_col`, one clock after `disp_col` is presented. It is 0 when `disp_col` is 80 or more.
- R10: The fill side is marked empty at each swap. Slots captured for an earlier row do not count toward the next row's completeness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh | input | 1 | CPU refresh strobe, active high, synchronous to clk |
| mem_req | input | 1 | CPU memory request, active high, synchronous to clk |
| ref_addr | input | 7 | Low address bits during refresh (refresh counter) |
| data_in | input | 8 | CPU data bus |
| fill_en | input | 1 | Capture enable set by software |
| line_end | input | 1 | One-clock pulse at the end of each scanline |
| disp_col | input | 7 | Column being displayed |
| glyph_code | output | 8 | Character code for the glyph ROM |
| glyph_row | output | 3 | Scanline within the character cell |
| underrun | output | 1 | Last promoted row was incomplete |

## Verification
The assertions assume that `refresh`, `mem_req` and `line_end` are already synchronous to `clk`. They also assume that a refresh cycle lasts at least one clock and that `line_end` is a single-clock pulse. The stimulus drives every strobe on the falling edge and holds it for exactly one clock. It then drops the strobe for a clock before the next capture, so every refresh has a clean rising edge. Software is expected to keep a transfer inside one 128-byte window. The bench also steps indices 80 to 127 on purpose, to show that those captures are discarded.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int DEF_DATA_W  = 8;
    localparam int DEF_IDX_W   = 7;
    localparam int DEF_ROW_LEN = 80;
    localparam int DEF_CELL_H  = 8;
    localparam int NUM_BANKS   = 2;
endpackage

// File: rtl/rrf_scan_timer.sv
module rrf_scan_timer #(
    parameter int CELL_H = rrf_pkg::DEF_CELL_H,
    parameter int LINE_W = $clog2(CELL_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    output logic [LINE_W-1:0] scan_line,
    output logic              disp_side,
    output logic              swap
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(CELL_H - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              side;
    } timer_t;

    timer_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        swap = line_end && (s_q.line == LAST_LINE);
        if (line_end) begin
            if (swap) begin
                s_d.line = '0;
                s_d.side = ~s_q.side;
            end else begin
                s_d.line = s_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scan_line = s_q.line;
    assign disp_side = s_q.side;

    p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && s_q.line != LAST_LINE) |=> (s_q.line == $past(s_q.line) + 1'b1));
    p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(s_q));
    p_swap_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (s_q.side != $past(s_q.side)) && (s_q.line == '0));
endmodule

// File: rtl/rrf_fill_ctrl.sv
module rrf_fill_ctrl #(
    parameter int DATA_W  = rrf_pkg::DEF_DATA_W,
    parameter int IDX_W   = rrf_pkg::DEF_IDX_W,
    parameter int ROW_LEN = rrf_pkg::DEF_ROW_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh,
    input  logic              mem_req,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  ref_idx,
    input  logic [DATA_W-1:0] data_in,
    input  logic              swap,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              underrun
);
    localparam logic [IDX_W-1:0] LEN_I = IDX_W'(ROW_LEN);

    typedef struct packed {
        logic               cyc_prev;
        logic [ROW_LEN-1:0] filled;
        logic               under;
    } fill_t;

    fill_t s_d, s_q;
    logic               cyc;
    logic [ROW_LEN-1:0] filled_now;

    always_comb begin
        cyc        = refresh && mem_req;
        wr_en      = cyc && !s_q.cyc_prev && fill_en && (ref_idx < LEN_I);
        wr_idx     = ref_idx;
        wr_data    = data_in;
        filled_now = s_q.filled;
        if (wr_en) filled_now[wr_idx] = 1'b1;
        s_d          = s_q;
        s_d.cyc_prev = cyc;
        s_d.filled   = filled_now;
        if (swap) begin
            s_d.under  = ~(&filled_now);
            s_d.filled = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign underrun = s_q.under;

    p_fill_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> ($countones(s_q.filled) == 0));
    p_full_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && $countones(s_q.filled) == ROW_LEN) |=> !underrun);
    p_short_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !wr_en && $countones(s_q.filled) < ROW_LEN) |=> underrun);
    p_one_per_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/rrf_row_store.sv
module rrf_row_store #(
    parameter int DATA_W  = rrf_pkg::DEF_DATA_W,
    parameter int IDX_W   = rrf_pkg::DEF_IDX_W,
    parameter int ROW_LEN = rrf_pkg::DEF_ROW_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_side,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LEN_I = IDX_W'(ROW_LEN);

    genvar b;
    generate
        for (b = 0; b < rrf_pkg::NUM_BANKS; b++) begin : g_bank
            logic [DATA_W-1:0] bank_q [ROW_LEN];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < ROW_LEN; i++) bank_q[i] <= '0;
                end else if (wr_en && (wr_side == 1'(b)) && (wr_idx < LEN_I)) begin
                    bank_q[wr_idx] <= wr_data;
                end
            end
        end
    endgenerate

    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_idx < LEN_I)
            rd_d = rd_side ? g_bank[1].bank_q[rd_idx] : g_bank[0].bank_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    p_wr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < LEN_I));
    p_wr_not_display_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_side != rd_side));
    p_rd_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= LEN_I) |=> (rd_data == '0));
endmodule

// File: rtl/refresh_row_fetcher.sv
module refresh_row_fetcher #(
    parameter int DATA_W  = rrf_pkg::DEF_DATA_W,
    parameter int IDX_W   = rrf_pkg::DEF_IDX_W,
    parameter int ROW_LEN = rrf_pkg::DEF_ROW_LEN,
    parameter int CELL_H  = rrf_pkg::DEF_CELL_H
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      refresh,
    input  logic                      mem_req,
    input  logic [IDX_W-1:0]          ref_addr,
    input  logic [DATA_W-1:0]         data_in,
    input  logic                      fill_en,
    input  logic                      line_end,
    input  logic [IDX_W-1:0]          disp_col,
    output logic [DATA_W-1:0]         glyph_code,
    output logic [$clog2(CELL_H)-1:0] glyph_row,
    output logic                      underrun
);
    localparam int LINE_W = $clog2(CELL_H);

    typedef struct packed {
        logic [LINE_W-1:0] row;
    } out_t;

    logic              swap, disp_side, wr_en;
    logic [LINE_W-1:0] scan_line;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    out_t              o_d, o_q;

    rrf_scan_timer #(.CELL_H(CELL_H), .LINE_W(LINE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .scan_line(scan_line), .disp_side(disp_side), .swap(swap)
    );

    rrf_fill_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROW_LEN(ROW_LEN)) u_fill (
        .clk(clk), .rst_n(rst_n), .refresh(refresh), .mem_req(mem_req),
        .fill_en(fill_en), .ref_idx(ref_addr), .data_in(data_in), .swap(swap),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .underrun(underrun)
    );

    rrf_row_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ROW_LEN(ROW_LEN)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(~disp_side),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_side(disp_side),
        .rd_idx(disp_col), .rd_data(glyph_code)
    );

    always_comb begin
        o_d     = o_q;
        o_d.row = scan_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign glyph_row = o_q.row;

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fill_en && refresh && mem_req));
    p_row_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (glyph_row == $past(scan_line)));
endmodule

// File: tb/refresh_row_fetcher_tb.sv
`timescale 1ns/1ps
module refresh_row_fetcher_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh = 1'b0, mem_req = 1'b0, fill_en = 1'b0, line_end = 1'b0;
    logic [6:0] ref_addr = '0, disp_col = '0;
    logic [7:0] data_in = '0;
    logic [7:0] glyph_code;
    logic [2:0] glyph_row;
    logic       underrun;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    int bank_m [2][80];
    int filled_m [80];
    int side_m = 0, line_m = 0, under_m = 0;

    always #2.5 clk = ~clk;

    refresh_row_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .refresh(refresh), .mem_req(mem_req),
        .ref_addr(ref_addr), .data_in(data_in), .fill_en(fill_en),
        .line_end(line_end), .disp_col(disp_col), .glyph_code(glyph_code),
        .glyph_row(glyph_row), .underrun(underrun)
    );

    function automatic int pat(int i, int row);
        return (i * 37 + row * 11 + 5) & 255;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cap(int idx, int d, bit rf, bit mr, bit en);
        @(negedge clk);
        ref_addr = 7'(idx); data_in = 8'(d);
        refresh = rf; mem_req = mr; fill_en = en;
        @(negedge clk);
        refresh = 1'b0; mem_req = 1'b0;
        if (rf && mr && en && idx < 80) begin
            bank_m[1 - side_m][idx] = d;
            filled_m[idx] = 1;
        end
    endtask

    task automatic pulse_line();
        @(negedge clk); line_end = 1'b1;
        @(negedge clk); line_end = 1'b0;
        if (line_m == 7) begin
            int cnt = 0;
            for (int i = 0; i < 80; i++) cnt += filled_m[i];
            under_m = (cnt < 80) ? 1 : 0;
            for (int i = 0; i < 80; i++) filled_m[i] = 0;
            line_m = 0;
            side_m = 1 - side_m;
        end else begin
            line_m++;
        end
    endtask

    task automatic chk_col(int c, string req);
        int exp;
        @(negedge clk); disp_col = 7'(c);
        @(negedge clk);
        exp = (c < 80) ? bank_m[side_m][c] : 0;
        check(int'(glyph_code) == exp, req, int'(glyph_code), exp);
        check(int'(glyph_row) == line_m, "R6 glyph_row", int'(glyph_row), line_m);
    endtask

    task automatic swap_row(string req);
        for (int l = 0; l < 8; l++) pulse_line();
        check(int'(underrun) == under_m, req, int'(underrun), under_m);
    endtask

    task automatic show_row(string req);
        for (int l = 0; l < 8; l++) begin
            for (int c = 0; c < 80; c++) chk_col(c, req);
            pulse_line();
        end
    endtask

    initial begin
        for (int s = 0; s < 2; s++) for (int i = 0; i < 80; i++) bank_m[s][i] = 0;
        for (int i = 0; i < 80; i++) filled_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(glyph_code == 8'd0, "R1 glyph_code", int'(glyph_code), 0);
        check(glyph_row == 3'd0, "R1 glyph_row", int'(glyph_row), 0);
        check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);
        for (int c = 0; c < 80; c += 7) chk_col(c, "R1 bank zero");

        // R2: fill full row
        for (int i = 0; i < 80; i++) cap(i, pat(i, 1), 1, 1, 1);
        // R3: out-of-range indices discarded
        for (int i = 80; i < 128; i++) cap(i, 8'hA5 ^ i, 1, 1, 1);
        // R4: fill_en low ignored
        for (int i = 0; i < 80; i += 5) cap(i, 8'h3C, 1, 1, 0);
        // R5: one strobe alone ignored
        for (int i = 1; i < 80; i += 6) cap(i, 8'hC3, 0, 1, 1);
        for (int i = 2; i < 80; i += 6) cap(i, 8'h99, 1, 0, 1);

        // R6/R7: display unchanged until the eighth line_end
        for (int l = 0; l < 7; l++) begin
            chk_col(l * 9, "R7 display before swap");
            pulse_line();
        end
        chk_col(3, "R6 no swap before last line");
        pulse_line();
        check(int'(underrun) == under_m, "R8 full row underrun", int'(underrun), under_m);

        // line 0 of row A with partial fill of the next row in between (R7)
        for (int c = 0; c < 80; c++) begin
            chk_col(c, "R2 R3 R4 R5 captured data");
            if (c < 40) cap(c, pat(c, 2), 1, 1, 1);
        end
        pulse_line();
        for (int l = 1; l < 8; l++) begin
            for (int c = 0; c < 80; c++) chk_col(c, "R7 repeated row");
            if (l == 3) for (int c = 80; c < 128; c++) chk_col(c, "R9 column beyond row");
            pulse_line();
        end
        check(int'(underrun) == under_m, "R8 short row underrun", int'(underrun), under_m);

        // R10: fill the other half into the bank that was full before
        for (int i = 40; i < 80; i++) cap(i, pat(i, 3), 1, 1, 1);
        show_row("R8 partial row contents");
        check(int'(underrun) == under_m, "R10 fill side emptied", int'(underrun), under_m);

        // full row with a duplicate write
        for (int i = 0; i < 80; i++) cap(i, pat(i, 4), 1, 1, 1);
        cap(0, 8'h5A, 1, 1, 1);
        swap_row("R8 R10 complete row");
        for (int c = 0; c < 80; c++) chk_col(c, "R2 duplicate slot last write");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule